// File: doc/BRIEF.md
# Current-Source Bridge Gate Generator

This block turns three two-level leg commands, each the output of a comparison between a modulating signal and a carrier, into the six gate signals of a three-phase current-source bridge. The active gates come from the line relationships between the leg commands. A line with a positive difference closes the top switch of one leg and the bottom switch of another. When all three commands are equal the bridge needs a zero current state. The block then shorts a single leg by closing both its top and bottom switch.

The leg that takes the short is chosen by a phase distributor. An unsigned synchronising phase word is split into three equal windows, and each leg owns one of them. Each leg therefore carries the short for a third of every period. This keeps the leg currents balanced. On every change of the selected top or bottom switch, the incoming switch closes first. The outgoing switch opens a programmable number of clocks later. The input current thus always has a path.

A registered fault flag reports any gate vector that has no top switch or no bottom switch closed.

Top module: `csi_gate_gen`

## Requirements
- R1: While reset is asserted, and after its release until the inputs differ, the gate vector is 6'b001001. Gate bit i drives switch i+1, so switches 1 and 4 are closed and the short sits on leg a. The fault flag is 0.
- R2: The top switches of legs a, b and c are switches 1, 3 and 5. The bottom switches are switches 4, 6 and 2. With leg commands {a,b,c}: switch 1 = a&~b, switch 4 = b&~a, switch 3 = b&~c, switch 6 = c&~b, switch 5 = c&~a and switch 2 = a&~c.
- R3: When a, b and c are equal, the settled gate vector closes the top and bottom switch of exactly one leg. The pairs are 1-4 for leg a, 3-6 for leg b and 5-2 for leg c.
- R4: With T = 2^PHASE_W/3 (integer division), phase values below T pick leg a. Values from T to 2T-1 pick leg b. Values of 2T and above pick leg c.
- R5: The gate vector always has one or two top switches closed and one or two bottom switches closed.
- R6: When the selected switch of a group changes, the new switch closes one clock after the input changes. The old switch stays closed together with it for overlap_cfg+1 clocks and then opens.
- R7: The fault flag is 1 exactly one clock after a gate vector with no top switch or no bottom switch closed. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| leg_cmd | input | 3 | Leg commands, bit 2 = leg a, bit 1 = leg b, bit 0 = leg c |
| sync_phase | input | PHASE_W | Synchronising phase word for the short distributor |
| overlap_cfg | input | OVL_W | Extra overlap clocks on a switch change |
| gate_o | output | 6 | Gate vector, bit i drives switch i+1 |
| fault_o | output | 1 | Missing top or bottom switch detected |

## Verification
The bench visits every active state and shorts on all three legs. It probes the phase words on both sides of each window edge and at the top of the range. A wrong boundary would put the short on the neighbouring leg. A swapped decode term would close the wrong pair or two switches of one group. A faulty overlap sequencer would either show a gap, with the outgoing switch dropping before the incoming one closes, or hold the overlap for a number of clocks other than overlap_cfg+1. A mid-run reset checks that the gates return to the leg-a short at once.

// File: rtl/csi_gate_pkg.sv
package csi_gate_pkg;
  localparam int unsigned NLEG = 3;
  typedef logic [NLEG-1:0] leg_vec_t;
  localparam leg_vec_t LEG_A = 3'b001;
endpackage

// File: rtl/csi_active_decode.sv
module csi_active_decode
  import csi_gate_pkg::*;
(
  input  logic     cmd_a,
  input  logic     cmd_b,
  input  logic     cmd_c,
  output leg_vec_t top_o,
  output leg_vec_t bot_o,
  output logic     zero_o
);
  // index 0 = leg a, 1 = leg b, 2 = leg c
  always_comb begin
    top_o[0] = cmd_a & ~cmd_b;
    top_o[1] = cmd_b & ~cmd_c;
    top_o[2] = cmd_c & ~cmd_a;
    bot_o[0] = cmd_b & ~cmd_a;
    bot_o[1] = cmd_c & ~cmd_b;
    bot_o[2] = cmd_a & ~cmd_c;
    zero_o   = (cmd_a == cmd_b) && (cmd_b == cmd_c);
  end
endmodule

// File: rtl/csi_short_distrib.sv
module csi_short_distrib
  import csi_gate_pkg::*;
#(
  parameter int unsigned PHASE_W = 8
) (
  input  logic [PHASE_W-1:0] phase_i,
  output leg_vec_t           sel_o
);
  localparam logic [PHASE_W:0] SPAN  = (PHASE_W+1)'(1) << PHASE_W;
  localparam logic [PHASE_W:0] THIRD = SPAN / 3;
  localparam logic [PHASE_W:0] TWO_THIRD = THIRD * 2;

  logic [PHASE_W:0] ph_ext;

  always_comb begin
    ph_ext = {1'b0, phase_i};
    if (ph_ext < THIRD)          sel_o = 3'b001;
    else if (ph_ext < TWO_THIRD) sel_o = 3'b010;
    else                         sel_o = 3'b100;
  end
endmodule

// File: rtl/csi_overlap_seq.sv
module csi_overlap_seq
  import csi_gate_pkg::*;
#(
  parameter int unsigned OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  leg_vec_t         tgt_d,
  input  logic [OVL_W-1:0] ovl_i,
  output leg_vec_t         sw_o
);
  leg_vec_t         tgt_q, tgt_nx;
  leg_vec_t         cur_q, cur_nx;
  logic [OVL_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    tgt_nx = tgt_d;
    cur_nx = cur_q;
    cnt_nx = cnt_q;
    if (tgt_q == cur_q) begin
      cnt_nx = '0;
    end else if (cnt_q >= ovl_i) begin
      cur_nx = tgt_q;
      cnt_nx = '0;
    end else begin
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= LEG_A;
      cur_q <= LEG_A;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_nx;
      cur_q <= cur_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign sw_o = cur_q | tgt_q;
endmodule

// File: rtl/csi_gate_gen.sv
module csi_gate_gen
  import csi_gate_pkg::*;
#(
  parameter int unsigned PHASE_W = 8,
  parameter int unsigned OVL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         leg_cmd,
  input  logic [PHASE_W-1:0] sync_phase,
  input  logic [OVL_W-1:0]   overlap_cfg,
  output logic [5:0]         gate_o,
  output logic               fault_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  leg_vec_t dec_top, dec_bot, short_sel;
  logic     zero_st;
  leg_vec_t grp_tgt [2];
  leg_vec_t grp_sw  [2];

  csi_active_decode u_dec (
    .cmd_a (leg_cmd[2]),
    .cmd_b (leg_cmd[1]),
    .cmd_c (leg_cmd[0]),
    .top_o (dec_top),
    .bot_o (dec_bot),
    .zero_o(zero_st)
  );

  csi_short_distrib #(.PHASE_W(PHASE_W)) u_dist (
    .phase_i(sync_phase),
    .sel_o  (short_sel)
  );

  always_comb begin
    grp_tgt[0] = dec_top | (zero_st ? short_sel : '0);
    grp_tgt[1] = dec_bot | (zero_st ? short_sel : '0);
  end

  // group 0 = top switches, group 1 = bottom switches
  for (genvar g = 0; g < 2; g++) begin : g_grp
    csi_overlap_seq #(.OVL_W(OVL_W)) u_seq (
      .clk  (clk),
      .rst_n(rst_n & rst_int_n),
      .tgt_d(grp_tgt[g]),
      .ovl_i(overlap_cfg),
      .sw_o (grp_sw[g])
    );
  end

  assign gate_o = {grp_sw[1][1], grp_sw[0][2], grp_sw[1][0],
                   grp_sw[0][1], grp_sw[1][2], grp_sw[0][0]};

  logic fault_q, fault_nx;
  always_comb fault_nx = (grp_sw[0] == '0) || (grp_sw[1] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (!rst_int_n) fault_q <= 1'b0;
    else                fault_q <= fault_nx;
  end
  assign fault_o = fault_q;
endmodule

// File: rtl/csi_gate_gen_chk.sv
module csi_gate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] gate,
  input logic       fault
);
  logic [2:0] top_w, bot_w;
  assign top_w = {gate[4], gate[2], gate[0]};
  assign bot_w = {gate[5], gate[3], gate[1]};

  p_top_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(top_w) >= 1) && ($countones(top_w) <= 2));

  p_bot_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bot_w) >= 1) && ($countones(bot_w) <= 2));

  p_top_make_before_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(top_w) & ~top_w)) |-> ($countones($past(top_w)) >= 2));

  p_bot_make_before_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(bot_w) & ~bot_w)) |-> ($countones($past(bot_w)) >= 2));

  p_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault);
endmodule

bind csi_gate_gen csi_gate_gen_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .gate (gate_o),
  .fault(fault_o)
);

// File: tb/csi_gate_gen_tb.sv
module csi_gate_gen_tb;
  localparam int PW = 8;
  localparam int OW = 4;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    leg_cmd;
  logic [PW-1:0] sync_phase;
  logic [OW-1:0] overlap_cfg;
  logic [5:0]    gate_o;
  logic          fault_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  csi_gate_gen #(.PHASE_W(PW), .OVL_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .leg_cmd(leg_cmd), .sync_phase(sync_phase),
    .overlap_cfg(overlap_cfg), .gate_o(gate_o), .fault_o(fault_o)
  );

  // {leg_cmd, phase, expected gate}; T = 85 for PW = 8
  localparam logic [16:0] VEC [NV] = '{
    {3'b100, 8'd0,   6'b000011},  // R2 1-2
    {3'b110, 8'd0,   6'b000110},  // R2 3-2
    {3'b010, 8'd0,   6'b001100},  // R2 3-4
    {3'b011, 8'd0,   6'b011000},  // R2 5-4
    {3'b001, 8'd0,   6'b110000},  // R2 5-6
    {3'b101, 8'd0,   6'b100001},  // R2 1-6
    {3'b000, 8'd10,  6'b001001},  // R3 leg a
    {3'b111, 8'd100, 6'b100100},  // R3 leg b
    {3'b000, 8'd200, 6'b010010},  // R3 leg c
    {3'b111, 8'd84,  6'b001001},  // R4 T-1
    {3'b111, 8'd85,  6'b100100},  // R4 T
    {3'b000, 8'd169, 6'b100100},  // R4 2T-1
    {3'b000, 8'd170, 6'b010010},  // R4 2T
    {3'b111, 8'd255, 6'b010010}   // R4 max
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int ovl_cnt;
    rst_n = 1'b0;
    leg_cmd = 3'b000;
    sync_phase = '0;
    overlap_cfg = 4'd1;
    repeat (3) @(negedge clk);
    check("R1 reset gates", gate_o, 6'b001001);
    check("R1 reset fault", {5'b0, fault_o}, 6'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", gate_o, 6'b001001);

    for (int i = 0; i < NV; i++) begin
      leg_cmd    = VEC[i][16:14];
      sync_phase = VEC[i][13:6];
      repeat (6) @(negedge clk);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), gate_o, VEC[i][5:0]);
      check("R7 fault low", {5'b0, fault_o}, 6'b0);
    end

    // R6: overlap of overlap_cfg+1 clocks on a top change a -> b
    overlap_cfg = 4'd3;
    leg_cmd = 3'b100;
    repeat (8) @(negedge clk);
    check("R6 start state", gate_o, 6'b000011);
    leg_cmd = 3'b110;
    @(negedge clk);
    check("R6 incoming closes after one clock", gate_o, 6'b000111);
    ovl_cnt = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (gate_o[0]) ovl_cnt++;
    end
    check("R6 overlap length", 6'(ovl_cnt), 6'd4);
    check("R6 settled", gate_o, 6'b000110);

    // R6 with zero extra overlap: bottom change c -> a
    overlap_cfg = 4'd0;
    leg_cmd = 3'b010;
    @(negedge clk);
    check("R6 zero cfg overlap", gate_o, 6'b001110);
    @(negedge clk);
    check("R6 zero cfg release", gate_o, 6'b001100);

    // R1: mid-run reset returns to leg-a short at once
    leg_cmd = 3'b001;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", gate_o, 6'b001001);
    leg_cmd = 3'b000;
    sync_phase = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset hold", gate_o, 6'b001001);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule